// File: doc/BRIEF.md
# Programmable DRAM Column Address Mapper

This block builds a DRAM column address from a linear host address. Column bits 0 to 5 are copied straight from host bits 0 to 5. Each of four selectors, numbered 0 to 3, picks one host bit for one higher column bit. The host bit it picks is a fixed base (6 + selector number) plus a 5-bit offset that software programs. A bus-width input moves the column bit each selector drives. A memory-family input decides whether column bit 10 may be used. That bit stays free for auto-precharge on DDR2/DDR3 parts and may carry an address bit on LPDDR2/LPDDR3 parts.

The four offsets live in one 32-bit configuration register that software can read and write. They are meant to be set only while the controller is idle. The block drops any write that arrives while its idle input is low and raises a sticky error flag. It also raises a sticky flag when a written offset is outside the legal set. The column address is registered, so it follows the host address one clock later.

Top module: `colmap_top`

## Requirements
- R1: With selector s enabled, the column bit it drives equals host address bit (6 + s + offset_s). Legal offsets are 0 to 7.
- R2: An offset of 31 on selectors 1, 2 or 3 marks that selector unused. Its column bit outputs 0 and no configuration error is raised.
- R3: Offsets 8 to 30 on any selector, and 31 on selector 0, are illegal. The column bit of that selector outputs 0, and `cfg_err_o` rises at the write and stays high until reset.
- R4: Width code 0 (full): selectors 0, 1, 2 and 3 drive column bits 6, 7, 8 and 9.
- R5: Width code 1 (half): selectors 0, 1 and 2 drive column bits 7, 8 and 9. Selector 3 drives column bit 11, or bit 10 when `lpddr_i` is 1.
- R6: Width code 2 (quarter): selectors 0 and 1 drive column bits 8 and 9. Selector 2 drives bit 11 (bit 10 when `lpddr_i`=1). Selector 3 drives bit 13 (bit 11 when `lpddr_i`=1).
- R7: When `lpddr_i` is 0, column bit 10 is always 0.
- R8: Register layout: selector 0 at bits 4:0, selector 1 at bits 12:8, selector 2 at bits 20:16, selector 3 at bits 28:24. Every other bit reads 0. All fields reset to 0.
- R9: A write while `idle_i` is 0 leaves the register unchanged, and `wr_err_o` rises and stays high until reset.
- R10: Column bits 0 to 5 copy host bits 0 to 5 in every mode. Width code 3 behaves as full width. A column bit that no selector drives is 0.
- R11: `col_addr_o` reflects the host address, mode inputs and configuration sampled at the previous rising clock edge. During reset it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_i | input | 1 | Controller idle; register writes are accepted only while it is high |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read value |
| bus_width_i | input | 2 | 0 full, 1 half, 2 quarter, 3 treated as full |
| lpddr_i | input | 1 | 1 for LPDDR2/LPDDR3 placement, 0 for DDR2/DDR3 |
| host_addr_i | input | 17 | Linear host address |
| col_addr_o | output | 14 | Registered column address |
| wr_err_o | output | 1 | Sticky: a write was dropped while busy |
| cfg_err_o | output | 1 | Sticky: an illegal offset was written |

## Verification
The hardest cases to reach from the ports are the illegal-offset cases, and the distinction between a legal unused code and an illegal one. Both force a column bit to 0, so the output alone cannot tell them apart. The stimulus table first writes offset 31 to the upper selectors and checks that the error flag is still low. Only then does it write 31 to selector 0 and an out-of-range value to another selector, so the rise of the sticky flag is tied to the exact write that should cause it. Every vector also rewrites the register and waits one extra edge, so each output check reflects the newly written configuration and not the old one.

// File: rtl/colmap_pkg.sv
package colmap_pkg;

    localparam int NSEL        = 4;
    localparam int FIELD_W     = 5;
    localparam int SLOT_W      = 8;
    localparam int REG_W       = 32;
    localparam int BASE0       = 6;
    localparam int MAX_OFFSET  = 7;
    localparam logic [FIELD_W-1:0] UNUSED_CODE = 5'd31;

    typedef enum logic [1:0] {
        WM_FULL    = 2'd0,
        WM_HALF    = 2'd1,
        WM_QUARTER = 2'd2,
        WM_RSVD    = 2'd3
    } width_mode_e;

    // Selector 0 has no unused code; the others accept 31 as unused.
    function automatic logic field_legal(input int sel, input logic [FIELD_W-1:0] v);
        return (v <= FIELD_W'(MAX_OFFSET)) || (v == UNUSED_CODE && sel != 0);
    endfunction

    // Destination column bit of a selector, from bus width and memory family.
    function automatic logic [4:0] dest_bit(input int sel, input width_mode_e m, input logic lp);
        logic [4:0] d;
        d = 5'(BASE0 + sel);
        case (m)
            WM_HALF: begin
                case (sel)
                    0:       d = 5'd7;
                    1:       d = 5'd8;
                    2:       d = 5'd9;
                    default: d = lp ? 5'd10 : 5'd11;
                endcase
            end
            WM_QUARTER: begin
                case (sel)
                    0:       d = 5'd8;
                    1:       d = 5'd9;
                    2:       d = lp ? 5'd10 : 5'd11;
                    default: d = lp ? 5'd11 : 5'd13;
                endcase
            end
            default: d = 5'(BASE0 + sel);
        endcase
        return d;
    endfunction

endpackage

// File: rtl/colmap_regs.sv
module colmap_regs
    import colmap_pkg::*;
#(
    parameter int N_SEL = NSEL,
    parameter int FW    = FIELD_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      idle_i,
    input  logic                      we_i,
    input  logic [REG_W-1:0]          wdata_i,
    output logic [N_SEL-1:0][FW-1:0]  fields_o,
    output logic [REG_W-1:0]          rdata_o,
    output logic                      wr_err_o,
    output logic                      cfg_err_o
);

    typedef struct packed {
        logic [N_SEL-1:0][FW-1:0] fld;
        logic                     werr;
        logic                     cerr;
    } regs_t;

    regs_t st_d, st_q;
    logic  accept;
    logic  bad_field;

    always_comb begin
        st_d      = st_q;
        accept    = we_i && idle_i;
        bad_field = 1'b0;
        for (int s = 0; s < N_SEL; s++) begin
            if (!field_legal(s, wdata_i[s*SLOT_W +: FW]))
                bad_field = 1'b1;
        end
        if (accept) begin
            for (int s = 0; s < N_SEL; s++)
                st_d.fld[s] = wdata_i[s*SLOT_W +: FW];
            if (bad_field)
                st_d.cerr = 1'b1;
        end
        if (we_i && !idle_i)
            st_d.werr = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata_o = '0;
        for (int s = 0; s < N_SEL; s++)
            rdata_o[s*SLOT_W +: FW] = st_q.fld[s];
    end

    assign fields_o  = st_q.fld;
    assign wr_err_o  = st_q.werr;
    assign cfg_err_o = st_q.cerr;

    p_busy_write_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !idle_i) |=> $stable(rdata_o));
    p_werr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err_o |=> wr_err_o);
    p_werr_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_err_o && !(we_i && !idle_i)) |=> !wr_err_o);
    p_cerr_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |=> cfg_err_o);

endmodule

// File: rtl/colmap_decode.sv
module colmap_decode
    import colmap_pkg::*;
#(
    parameter int N_SEL = NSEL,
    parameter int FW    = FIELD_W,
    parameter int AW    = 17,
    parameter int CW    = 14,
    localparam int SRCW = $clog2(AW),
    localparam int DSTW = $clog2(CW)
) (
    input  logic [N_SEL-1:0][FW-1:0]   fields_i,
    input  logic [1:0]                 mode_i,
    input  logic                       lp_i,
    output logic [N_SEL-1:0]           en_o,
    output logic [N_SEL-1:0][SRCW-1:0] src_o,
    output logic [N_SEL-1:0][DSTW-1:0] dst_o
);

    width_mode_e mode;
    assign mode = width_mode_e'(mode_i);

    for (genvar g = 0; g < N_SEL; g++) begin : g_sel
        logic [FW:0] src_full;
        logic [4:0]  dst_full;
        logic        legal;

        always_comb begin
            src_full = (FW+1)'(BASE0 + g) + {1'b0, fields_i[g]};
            dst_full = dest_bit(g, mode, lp_i);
            legal    = field_legal(g, fields_i[g]) && (fields_i[g] != UNUSED_CODE);
            en_o[g]  = legal && (src_full < (FW+1)'(AW)) && (dst_full < 5'(CW));
            src_o[g] = src_full[SRCW-1:0];
            dst_o[g] = dst_full[DSTW-1:0];
        end
    end

endmodule

// File: rtl/colmap_top.sv
module colmap_top
    import colmap_pkg::*;
#(
    parameter int AW = 17,
    parameter int CW = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle_i,
    input  logic              reg_we_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    input  logic [1:0]        bus_width_i,
    input  logic              lpddr_i,
    input  logic [AW-1:0]     host_addr_i,
    output logic [CW-1:0]     col_addr_o,
    output logic              wr_err_o,
    output logic              cfg_err_o
);

    localparam int PASS = BASE0;
    localparam int SRCW = $clog2(AW);
    localparam int DSTW = $clog2(CW);

    logic [NSEL-1:0][FIELD_W-1:0] fields;
    logic [NSEL-1:0]              sel_en;
    logic [NSEL-1:0][SRCW-1:0]    sel_src;
    logic [NSEL-1:0][DSTW-1:0]    sel_dst;
    logic [CW-1:0]                col_d, col_q;

    colmap_regs #(.N_SEL(NSEL), .FW(FIELD_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .idle_i    (idle_i),
        .we_i      (reg_we_i),
        .wdata_i   (reg_wdata_i),
        .fields_o  (fields),
        .rdata_o   (reg_rdata_o),
        .wr_err_o  (wr_err_o),
        .cfg_err_o (cfg_err_o)
    );

    colmap_decode #(.N_SEL(NSEL), .FW(FIELD_W), .AW(AW), .CW(CW)) dec_i (
        .fields_i (fields),
        .mode_i   (bus_width_i),
        .lp_i     (lpddr_i),
        .en_o     (sel_en),
        .src_o    (sel_src),
        .dst_o    (sel_dst)
    );

    always_comb begin
        col_d = '0;
        for (int i = 0; i < PASS; i++)
            col_d[i] = host_addr_i[i];
        for (int s = 0; s < NSEL; s++) begin
            if (sel_en[s])
                col_d[sel_dst[s]] = host_addr_i[sel_src[s]];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) col_q <= '0;
        else        col_q <= col_d;
    end

    assign col_addr_o = col_q;

    p_passthru_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> col_addr_o[PASS-1:0] == $past(host_addr_i[PASS-1:0]));
    p_ddr_bit10_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !lpddr_i |=> col_addr_o[10] == 1'b0);
    p_unused_b9_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata_o[28:24] == UNUSED_CODE && (bus_width_i == 2'd0 || bus_width_i == 2'd3))
        |=> col_addr_o[9] == 1'b0);
    p_top_bits_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_width_i != 2'd2) |=> col_addr_o[13:12] == 2'b00);

endmodule

// File: tb/colmap_top_tb_top.sv
module colmap_top_tb_top;

    typedef struct packed {
        logic [1:0]  wm;
        logic        lp;
        logic [31:0] cfg;
        logic [16:0] host;
        logic [13:0] col;
        logic        cerr;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 32'h0000_0000, 17'h1F2A5, 14'h02A5, 1'b0}, // R4 full, offsets 0
        '{2'd0, 1'b0, 32'h0403_0201, 17'h02080, 14'h0240, 1'b0}, // R1 base+offset
        '{2'd1, 1'b0, 32'h0000_0000, 17'h003FF, 14'h0BBF, 1'b0}, // R5 half DDR, R7
        '{2'd1, 1'b1, 32'h0000_0000, 17'h003FF, 14'h07BF, 1'b0}, // R5 half LPDDR
        '{2'd2, 1'b0, 32'h0000_0000, 17'h003FF, 14'h2B3F, 1'b0}, // R6 quarter DDR, R7
        '{2'd2, 1'b1, 32'h0000_0000, 17'h003FF, 14'h0F3F, 1'b0}, // R6 quarter LPDDR
        '{2'd0, 1'b0, 32'h1F00_0000, 17'h003FF, 14'h01FF, 1'b0}, // R2 selector 3 unused
        '{2'd0, 1'b0, 32'h0700_0007, 17'h12000, 14'h0240, 1'b0}, // R1 max offset
        '{2'd3, 1'b0, 32'h0000_0000, 17'h00155, 14'h0155, 1'b0}, // R10 code 3 as full
        '{2'd2, 1'b0, 32'h1F1F_0000, 17'h003FF, 14'h033F, 1'b0}, // R2 two unused
        '{2'd0, 1'b0, 32'h0000_001F, 17'h003FF, 14'h03BF, 1'b1}, // R3 31 on selector 0
        '{2'd0, 1'b0, 32'h0009_0000, 17'h003FF, 14'h02FF, 1'b1}  // R3 offset 9
    };

    function automatic string vec_tag(input int i);
        case (i)
            0:       return "R4";
            1, 7:    return "R1";
            2, 3:    return "R5/R7";
            4, 5:    return "R6/R7";
            6, 9:    return "R2";
            8:       return "R10";
            default: return "R3";
        endcase
    endfunction

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        idle = 1'b1;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  wm = '0;
    logic        lp = 1'b0;
    logic [16:0] host = '0;
    logic [13:0] col;
    logic        werr, cerr;
    int          total = 0;
    int          bad = 0;
    logic        done = 1'b0;

    always #4 clk = ~clk;

    colmap_top dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .idle_i      (idle),
        .reg_we_i    (we),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .bus_width_i (wm),
        .lpddr_i     (lp),
        .host_addr_i (host),
        .col_addr_o  (col),
        .wr_err_o    (werr),
        .cfg_err_o   (cerr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R11 watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        host = 17'h1FFFF;
        repeat (3) @(negedge clk);
        chk("R11 reset col", 32'(col), 32'h0);
        chk("R8 reset rdata", rdata, 32'h0);
        chk("R9 reset werr", 32'(werr), 32'h0);
        chk("R3 reset cerr", 32'(cerr), 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            idle  = 1'b1;
            we    = 1'b1;
            wdata = VECS[i].cfg;
            wm    = VECS[i].wm;
            lp    = VECS[i].lp;
            host  = VECS[i].host;
            @(negedge clk);
            we = 1'b0;
            @(negedge clk);
            chk(vec_tag(i), 32'(col), 32'(VECS[i].col));
            chk(vec_tag(i), 32'(cerr), 32'(VECS[i].cerr));
        end

        // R8: field layout, unused bits read 0
        @(negedge clk);
        wm = 2'd0; lp = 1'b0;
        we = 1'b1; wdata = 32'hFF1F_E705;
        @(negedge clk);
        we = 1'b0;
        chk("R8 readback", rdata, 32'h1F1F_0705);
        chk("R9 werr before busy write", 32'(werr), 32'h0);

        // R9: write while busy is dropped
        idle = 1'b0; we = 1'b1; wdata = 32'h0000_0000;
        @(negedge clk);
        we = 1'b0; idle = 1'b1;
        chk("R9 busy write dropped", rdata, 32'h1F1F_0705);
        chk("R9 werr set", 32'(werr), 32'h1);
        @(negedge clk);
        chk("R9 werr sticky", 32'(werr), 32'h1);

        // R11: one cycle latency; R1 with offsets 5 and 7
        host = 17'h0;
        repeat (2) @(negedge clk);
        chk("R11 settle", 32'(col), 32'h0);
        host = 17'h04800;
        #1;
        chk("R11 no change before edge", 32'(col), 32'h0);
        @(negedge clk);
        chk("R1 offsets 5 and 7", 32'(col), 32'h00C0);
        chk("R3 cerr sticky", 32'(cerr), 32'h1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule